// File: doc/BRIEF.md
# Byte-Wide Memory Read Sequencer

This block sits on the host side of a parallel, byte-wide nonvolatile memory. The memory has an address bus, an active-low chip select, an active-low output gate and an 8-bit data bus that only the memory drives. A client presents a read request with an address. The sequencer then does four things in order:

- it drives the address and pulls chip select low;
- it opens the output gate late, after the access time from chip select minus the shorter access time from the output gate;
- it captures the byte once the full chip-select access time has passed and returns it with a one-cycle valid strobe;
- it releases the bus, closing the output gate first and lifting chip select on the following cycle, so the memory drops into standby.

Both access times are parameters counted in clock cycles. The defaults are 8 and 3 cycles, which is 80 ns and 30 ns at 100 MHz, so they cover a 70 ns part. A back-to-back option keeps chip select low when the next request, to a different address, arrives in the release cycle. The data port is an input only, so the controller never drives the shared bus.

Top module: `nvm_read_seq`

## Requirements
- R1: During and after reset, chip select and output gate are high (deasserted), busy is low and the valid strobe is low.
- R2: A request seen while idle is accepted on that clock edge. In the next cycle the address output equals the request address, chip select is low and busy is high. The output gate stays high when the output-gate access time is shorter than the chip-select access time.
- R3: The output gate goes low exactly ACC_CE−ACC_OE cycles after chip select went low. It stays low until the capture cycle.
- R4: Exactly ACC_CE cycles after chip select went low, the data output carries the byte present on the memory bus at that edge. The valid strobe is high for that single cycle, and busy goes low in that same cycle.
- R5: The output gate goes high in the capture cycle. Chip select goes high one cycle later unless a back-to-back request is accepted. The output gate is never low while chip select is high.
- R6: The address output does not change from acceptance until the capture cycle.
- R7: Requests presented while busy is high are ignored. The address and the returned byte of the read in progress are unchanged.
- R8: With back-to-back enabled, a request to a different address presented in the cycle after capture is accepted. Chip select stays low, the new address is driven, busy rises, and the full R3/R4 timing restarts.
- R9: A request to the same address presented in the cycle after capture is not taken back-to-back. Chip select goes high, busy stays low, and a request still held is accepted on the next edge from standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request; hold until busy is seen high |
| req_addr | input | ADDR_W | Byte address of the request |
| busy | output | 1 | High from acceptance until the byte is returned |
| rd_valid | output | 1 | One-cycle strobe marking rd_data valid |
| rd_data | output | DATA_W | Captured byte |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_dq | input | DATA_W | Data bus from the memory (never driven here) |

## Verification
The assertions check the following on every cycle:
- the output gate is never open while chip select is high;
- the strobe lasts one cycle, only after a cycle with the gate open;
- busy falls only together with the strobe;
- the address holds during an access;
- chip select rises only after the gate has closed;
- the timer stays in range.

Only the bench's scenarios can show the exact cycle counts from chip select to gate and to capture, and that the returned byte is right. The bench uses a memory model that returns a corrupted byte whenever either access time has not been met. The scenarios also cover requests ignored while busy, and the two release-cycle cases where chip select is held or lifted.

// File: rtl/nvm_read_pkg.sv
package nvm_read_pkg;

    localparam int DEF_ACC_CE = 8;
    localparam int DEF_ACC_OE = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ACCESS  = 2'd1,
        SEQ_RELEASE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic busy;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_STANDBY = '{ce_n: 1'b1, oe_n: 1'b1, busy: 1'b0};

    function automatic int gate_lead(input int acc_ce, input int acc_oe);
        return acc_ce - acc_oe;
    endfunction

endpackage

// File: rtl/nvm_access_timer.sv
module nvm_access_timer #(
    parameter int ACC_CE = nvm_read_pkg::DEF_ACC_CE,
    parameter int ACC_OE = nvm_read_pkg::DEF_ACC_OE
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic gate_hit,
    output logic done_hit
);
    localparam int LEAD = nvm_read_pkg::gate_lead(ACC_CE, ACC_OE);
    localparam int CW   = (ACC_CE < 2) ? 1 : $clog2(ACC_CE + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_hit = run && (cnt_q == CW'(ACC_CE - 1));

    generate
        if (LEAD > 0) begin : g_late_gate
            assign gate_hit = run && (cnt_q == CW'(LEAD - 1));
        end else begin : g_early_gate
            assign gate_hit = 1'b0;
        end
    endgenerate

    // R4: the count never passes the capture point while an access runs
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= CW'(ACC_CE - 1)));

endmodule

// File: rtl/nvm_byte_capture.sv
module nvm_byte_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= bus_in;
        end
    end
endmodule

// File: rtl/nvm_read_seq.sv
module nvm_read_seq
    import nvm_read_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int ACC_CE    = DEF_ACC_CE,
    parameter int ACC_OE    = DEF_ACC_OE,
    parameter bit BACK2BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq
);
    localparam int   LEAD      = gate_lead(ACC_CE, ACC_OE);
    localparam logic GATE_INIT = (LEAD > 0) ? 1'b1 : 1'b0;

    seq_state_t        state_q;
    bus_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic              valid_q;
    logic              gate_hit, done_hit;
    logic              take_idle, take_b2b, timer_start;

    assign take_idle   = (state_q == SEQ_IDLE) && req_valid;
    assign take_b2b    = BACK2BACK && (state_q == SEQ_RELEASE) && req_valid
                         && (req_addr != addr_q);
    assign timer_start = take_idle || take_b2b;

    nvm_access_timer #(.ACC_CE(ACC_CE), .ACC_OE(ACC_OE)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (timer_start),
        .run      (state_q == SEQ_ACCESS),
        .gate_hit (gate_hit),
        .done_hit (done_hit)
    );

    nvm_byte_capture #(.DATA_W(DATA_W)) i_capture (
        .clk    (clk),
        .rst    (rst),
        .load   (done_hit),
        .bus_in (mem_dq),
        .data_q (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            ctl_q   <= CTL_STANDBY;
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        addr_q     <= req_addr;
                        ctl_q.ce_n <= 1'b0;
                        ctl_q.oe_n <= GATE_INIT;
                        ctl_q.busy <= 1'b1;
                        state_q    <= SEQ_ACCESS;
                    end
                end
                SEQ_ACCESS: begin
                    if (gate_hit) begin
                        ctl_q.oe_n <= 1'b0;
                    end
                    if (done_hit) begin
                        valid_q    <= 1'b1;
                        ctl_q.oe_n <= 1'b1;
                        ctl_q.busy <= 1'b0;
                        state_q    <= SEQ_RELEASE;
                    end
                end
                SEQ_RELEASE: begin
                    if (take_b2b) begin
                        addr_q     <= req_addr;
                        ctl_q.oe_n <= GATE_INIT;
                        ctl_q.busy <= 1'b1;
                        state_q    <= SEQ_ACCESS;
                    end else begin
                        ctl_q.ce_n <= 1'b1;
                        state_q    <= SEQ_IDLE;
                    end
                end
                default: begin
                    ctl_q   <= CTL_STANDBY;
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign busy     = ctl_q.busy;
    assign rd_valid = valid_q;
    assign mem_addr = addr_q;
    assign mem_ce_n = ctl_q.ce_n;
    assign mem_oe_n = ctl_q.oe_n;

    // R5: output gate only opens inside a selected cycle
    assert_gate_inside_select_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);

    // R5: chip select lifts only after the gate closed one cycle earlier
    assert_gate_before_select_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> $past(mem_oe_n));

    // R4: strobe lasts one cycle and follows a cycle with the gate open
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
    assert_strobe_after_gate_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n));

    // R4: busy ends only together with the strobe
    assert_busy_ends_with_data_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rd_valid);

    // R6: address holds while an access stays in flight
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_addr));

endmodule

// File: tb/test_nvm_read_seq.sv
module test_nvm_read_seq;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;
    localparam int ACC_CE = 8;
    localparam int ACC_OE = 3;
    localparam int LEAD   = ACC_CE - ACC_OE;
    localparam int NVEC   = 6;

    // stimulus table: {address, inject a request while busy}
    localparam logic [ADDR_W:0] VEC [NVEC] = '{
        {18'h00000, 1'b0}, {18'h3FFFF, 1'b0}, {18'h12345, 1'b1},
        {18'h0A5A5, 1'b0}, {18'h20001, 1'b1}, {18'h1FFFE, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              busy, rd_valid, mem_ce_n, mem_oe_n;
    logic [DATA_W-1:0] rd_data, mem_dq;
    logic [ADDR_W-1:0] mem_addr;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nvm_read_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CE(ACC_CE), .ACC_OE(ACC_OE), .BACK2BACK(1'b1)
    ) i_nvm_read_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    function automatic logic [DATA_W-1:0] mem_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ {a[15:8]} ^ {6'b0, a[17:16]} ^ 8'h3C;
    endfunction

    // memory model: counts completed cycles of select (address stable) and gate
    logic [ADDR_W-1:0] last_addr = '0;
    int ce_done = 0;
    int oe_done = 0;
    always @(posedge clk) begin
        if (mem_ce_n)               ce_done <= 0;
        else if (mem_addr != last_addr) ce_done <= 1;
        else                        ce_done <= ce_done + 1;
        last_addr <= mem_addr;
        if (mem_oe_n) oe_done <= 0;
        else          oe_done <= oe_done + 1;
    end
    assign mem_dq = (mem_ce_n || mem_oe_n) ? 'z :
                    ((ce_done + 1 >= ACC_CE) && (oe_done + 1 >= ACC_OE)) ? mem_byte(mem_addr)
                                                                        : ~mem_byte(mem_addr);

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic issue(input logic [ADDR_W-1:0] a);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // called at the negedge after the accepting edge; returns at the strobe negedge
    task automatic access_phase(input logic [ADDR_W-1:0] a, input bit inject);
        chk("R2 select low after accept", mem_ce_n, 0);
        chk("R2 busy high after accept", busy, 1);
        chk("R2 address driven", mem_addr, a);
        for (int j = 0; j < ACC_CE; j++) begin
            if (inject && j == 1) begin
                req_valid = 1'b1;
                req_addr  = ~a;
            end
            if (inject && j == ACC_CE - 1) req_valid = 1'b0;
            chk("R3 gate timing", mem_oe_n, (j >= LEAD) ? 1'b0 : 1'b1);
            chk(inject ? "R7 address kept while busy" : "R6 address stable", mem_addr, a);
            chk("R4 no early strobe", rd_valid, 0);
            @(negedge clk);
        end
        chk("R4 strobe", rd_valid, 1);
        chk(inject ? "R7 byte of running read" : "R4 data", rd_data, mem_byte(a));
        chk("R4 busy low with strobe", busy, 0);
        chk("R5 gate closed in capture cycle", mem_oe_n, 1);
        chk("R5 select still low in capture cycle", mem_ce_n, 0);
    endtask

    task automatic release_phase();
        @(negedge clk);
        chk("R4 strobe single cycle", rd_valid, 0);
        chk("R5 select high after release", mem_ce_n, 1);
        chk("R5 gate high in standby", mem_oe_n, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 select in reset", mem_ce_n, 1);
        chk("R1 gate in reset", mem_oe_n, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 strobe after reset", rd_valid, 0);
        chk("R1 select after reset", mem_ce_n, 1);

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][ADDR_W:1]);
            access_phase(VEC[i][ADDR_W:1], VEC[i][0]);
            release_phase();
        end

        // R8: different address in release cycle, select held low
        issue(18'h01111);
        access_phase(18'h01111, 1'b0);
        issue(18'h02222);
        chk("R8 select held low", mem_ce_n, 0);
        chk("R8 busy rises again", busy, 1);
        access_phase(18'h02222, 1'b0);
        release_phase();

        // R9: same address in release cycle goes through standby
        issue(18'h03333);
        access_phase(18'h03333, 1'b0);
        req_valid = 1'b1;
        req_addr  = 18'h03333;
        @(negedge clk);
        chk("R9 select lifted", mem_ce_n, 1);
        chk("R9 not accepted", busy, 0);
        @(negedge clk);
        req_valid = 1'b0;
        access_phase(18'h03333, 1'b0);
        release_phase();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule